// File: doc/BRIEF.md
# Video Sync Reference Pin Controller

This block runs two bidirectional video reference pins. Each pin is either an input or an output. As an input, the pin can supply horizontal sync to the encoder core, and pin 2 can also supply a blanking level. As an output, the pin drives a reference pulse generated from the core's pixel and line counters. The start and end pixel positions of the pulse are programmable. Pin 2 has a second output mode in which the pulse is dropped on every line outside the active line range, so that the pin carries a composite-blanking-not signal.

Horizontal sync can come from a rising or falling edge on pin 1, from a rising or falling edge on pin 2, or from the frame-sync strobe decoded from an embedded CCIR 656 stream. Each pin has its own polarity bit. That bit sets both the level of its output pulse and which edge it detects as an input.

Top module: `sync_ref_top`

## Requirements
- R1: After reset both pins are inputs (`pin1Oe` = `pin2Oe` = 0). In that state `pin1Out`, `pin2Out`, `hSyncStrobe` and `extBlank` are all 0.
- R2: Each output enable equals its pin's direction bit (1 = output). A pin whose direction bit is 0 drives its `pinNOut` low.
- R3: With pin 2 an output and `pin2BlankSel` = 0, `pin2Out` is active while `pulseStart` <= `pixCount` < `pulseEnd` on every line, including lines outside the active range. The output appears one clock after the counters.
- R4: With pin 2 an output and `pin2BlankSel` = 1, the pulse is suppressed on any line below `firstLine` or above `lastLine`. Both limits belong to the active range.
- R5: A polarity bit of 0 gives an active-high output and rising-edge detection. A polarity bit of 1 gives an active-low output and falling-edge detection.
- R6: A detected edge on the selected sync pin gives a one-clock `hSyncStrobe` on the third rising clock edge after the pin changes, through two synchronizer flops and one edge register. A pin set as an output never gives a strobe, and neither does the edge of the opposite polarity.
- R7: With `embedSync` = 0, `syncFromPin2` chooses pin 1 (0) or pin 2 (1) as the sync source. With `embedSync` = 1, both pins are ignored and `hSyncStrobe` follows `embSyncStrobe` one clock later.
- R8: When `pulseStart` >= `pulseEnd` no pulse is produced on either pin.
- R9: `extBlank` is driven only when pin 2 is an input, `pin2BlankSel` = 1, `embedSync` = 0 and `syncFromPin2` = 1. It then shows the pin 2 level in its active polarity with the same two-flop latency as the strobe. In every other case it is 0.
- R10: Pin 1 as an output carries the horizontal reference pulse on every line, whatever the value of `pin2BlankSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pin1ActLow | input | 1 | Pin 1 polarity / edge select |
| pin1Drive | input | 1 | Pin 1 direction, 1 = output |
| pin2ActLow | input | 1 | Pin 2 polarity / edge select |
| pin2Drive | input | 1 | Pin 2 direction, 1 = output |
| pin2BlankSel | input | 1 | Pin 2 blanking role select |
| syncFromPin2 | input | 1 | Sync source, 0 = pin 1, 1 = pin 2 |
| embedSync | input | 1 | Take sync from embedded stream |
| embSyncStrobe | input | 1 | Decoded embedded frame-sync strobe |
| pixCount | input | PIX_W | Current pixel position |
| lineCount | input | LINE_W | Current line number |
| pulseStart | input | PIX_W | First pixel of the pulse |
| pulseEnd | input | PIX_W | Pixel after the last pulse pixel |
| firstLine | input | LINE_W | First active line |
| lastLine | input | LINE_W | Last active line |
| pin1In | input | 1 | Pin 1 pad input level |
| pin2In | input | 1 | Pin 2 pad input level |
| pin1Out | output | 1 | Pin 1 pad output level |
| pin1Oe | output | 1 | Pin 1 pad output enable |
| pin2Out | output | 1 | Pin 2 pad output level |
| pin2Oe | output | 1 | Pin 2 pad output enable |
| hSyncStrobe | output | 1 | One-clock horizontal sync strobe |
| extBlank | output | 1 | Blanking level taken from pin 2 |

## Verification
Pulse outputs are due one clock after the pixel and line counters are presented. Pin edges and pin levels reach `hSyncStrobe` and `extBlank` on the third rising edge after the change. The embedded strobe, and any change of mode that removes `extBlank`, shows after one edge. The bench drives inputs 2 ns after a rising edge. It then counts exactly that many rising edges and samples 2 ns after the last one. For each strobe it also checks the edge before and the edge after, to pin down the cycle and the one-clock width.

// File: rtl/sync_ref_pkg.sv
package sync_ref_pkg;
  // Strobes from the mode decoder to the datapath
  typedef struct packed {
    logic p1Drive;       // pin 1 is an output
    logic p2Drive;       // pin 2 is an output
    logic p2Cbn;         // pin 2 output excludes lines outside active range
    logic edgeFromPin1;  // pin 1 edges feed the sync strobe
    logic edgeFromPin2;  // pin 2 edges feed the sync strobe
    logic useEmbedded;   // embedded frame sync feeds the strobe
    logic blankEn;       // pin 2 level feeds the blanking output
  } refCtl_t;
endpackage

// File: rtl/sync_ref_ctrl.sv
module sync_ref_ctrl
  import sync_ref_pkg::*;
(
  input  logic    pin1Drive,
  input  logic    pin2Drive,
  input  logic    pin2BlankSel,
  input  logic    syncFromPin2,
  input  logic    embedSync,
  output refCtl_t ctl
);
  logic pinSrc;
  assign pinSrc = ~embedSync;

  always_comb begin
    ctl              = '0;
    ctl.p1Drive      = pin1Drive;
    ctl.p2Drive      = pin2Drive;
    ctl.p2Cbn        = pin2Drive & pin2BlankSel;
    ctl.useEmbedded  = embedSync;
    // a pin chosen as source contributes only while it is an input
    ctl.edgeFromPin1 = pinSrc & ~syncFromPin2 & ~pin1Drive;
    ctl.edgeFromPin2 = pinSrc &  syncFromPin2 & ~pin2Drive;
    ctl.blankEn      = pinSrc &  syncFromPin2 & ~pin2Drive & pin2BlankSel;
  end
endmodule

// File: rtl/sync_ref_window.sv
module sync_ref_window #(
  parameter int PIX_W  = 11,
  parameter int LINE_W = 10
) (
  input  logic [PIX_W-1:0]  pixCount,
  input  logic [LINE_W-1:0] lineCount,
  input  logic [PIX_W-1:0]  pulseStart,
  input  logic [PIX_W-1:0]  pulseEnd,
  input  logic [LINE_W-1:0] firstLine,
  input  logic [LINE_W-1:0] lastLine,
  output logic              hWin,
  output logic              vWin
);
  logic spanValid;
  assign spanValid = pulseStart < pulseEnd;
  assign hWin = spanValid && (pixCount >= pulseStart) && (pixCount < pulseEnd);
  assign vWin = (lineCount >= firstLine) && (lineCount <= lastLine);
endmodule

// File: rtl/sync_ref_dp.sv
module sync_ref_dp
  import sync_ref_pkg::*;
#(
  parameter int PIX_W  = 11,
  parameter int LINE_W = 10,
  parameter int NPINS  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  refCtl_t           ctl,
  input  logic [NPINS-1:0]  actLow,
  input  logic [NPINS-1:0]  pinIn,
  input  logic              embSyncStrobe,
  input  logic [PIX_W-1:0]  pixCount,
  input  logic [LINE_W-1:0] lineCount,
  input  logic [PIX_W-1:0]  pulseStart,
  input  logic [PIX_W-1:0]  pulseEnd,
  input  logic [LINE_W-1:0] firstLine,
  input  logic [LINE_W-1:0] lastLine,
  output logic [NPINS-1:0]  pinOut,
  output logic [NPINS-1:0]  pinOe,
  output logic              hSyncStrobe,
  output logic              extBlank
);
  logic hWin, vWin;
  logic [NPINS-1:0] metaLvl, syncLvl, prevLvl, edgeHit, pulseReg, pulseNext, drive;
  logic strobeNext, blankNext;

  sync_ref_window #(.PIX_W(PIX_W), .LINE_W(LINE_W)) uWin (
    .pixCount(pixCount), .lineCount(lineCount),
    .pulseStart(pulseStart), .pulseEnd(pulseEnd),
    .firstLine(firstLine), .lastLine(lastLine),
    .hWin(hWin), .vWin(vWin)
  );

  assign drive        = {ctl.p2Drive, ctl.p1Drive};
  assign pulseNext[0] = hWin;
  assign pulseNext[1] = hWin & (~ctl.p2Cbn | vWin);

  for (genvar i = 0; i < NPINS; i++) begin : gPin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        metaLvl[i]  <= 1'b0;
        syncLvl[i]  <= 1'b0;
        prevLvl[i]  <= 1'b0;
        pulseReg[i] <= 1'b0;
      end else begin
        metaLvl[i]  <= pinIn[i];
        syncLvl[i]  <= metaLvl[i];
        prevLvl[i]  <= syncLvl[i];
        pulseReg[i] <= pulseNext[i];
      end
    end
    assign edgeHit[i] = actLow[i] ? (prevLvl[i] & ~syncLvl[i])
                                  : (~prevLvl[i] & syncLvl[i]);
    assign pinOut[i]  = drive[i] & (pulseReg[i] ^ actLow[i]);
    assign pinOe[i]   = drive[i];
  end

  assign strobeNext = ctl.useEmbedded ? embSyncStrobe
                    : ((ctl.edgeFromPin1 & edgeHit[0]) | (ctl.edgeFromPin2 & edgeHit[1]));
  assign blankNext  = ctl.blankEn & (syncLvl[1] ^ actLow[1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hSyncStrobe <= 1'b0;
      extBlank    <= 1'b0;
    end else begin
      hSyncStrobe <= strobeNext;
      extBlank    <= blankNext;
    end
  end

  // R8: an empty or inverted span never produces a pulse
  p_empty_span_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pulseStart >= pulseEnd) |=> (pulseReg == '0));

  // R4: composite-blanking output is silent outside the active lines
  p_cbn_vblank_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.p2Cbn && (lineCount < firstLine || lineCount > lastLine)) |=> !pulseReg[1]);

  // R3: plain reference output is present on any line inside the span
  p_href_all_lines_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.p2Cbn && pulseStart <= pixCount && pixCount < pulseEnd) |=> pulseReg[1]);

  // R6: a pin-derived strobe lasts a single clock
  p_strobe_width_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hSyncStrobe && !ctl.useEmbedded) |=>
      (!hSyncStrobe || ctl.useEmbedded || !$stable(ctl.edgeFromPin2)));

  // R9: blanking output only follows the input-plus-blanking mode
  p_blank_mode_r9: assert property (@(posedge clk) disable iff (!rstN)
    extBlank |-> $past(ctl.blankEn));
endmodule

// File: rtl/sync_ref_top.sv
module sync_ref_top
  import sync_ref_pkg::*;
#(
  parameter int PIX_W  = 11,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pin1ActLow,
  input  logic              pin1Drive,
  input  logic              pin2ActLow,
  input  logic              pin2Drive,
  input  logic              pin2BlankSel,
  input  logic              syncFromPin2,
  input  logic              embedSync,
  input  logic              embSyncStrobe,
  input  logic [PIX_W-1:0]  pixCount,
  input  logic [LINE_W-1:0] lineCount,
  input  logic [PIX_W-1:0]  pulseStart,
  input  logic [PIX_W-1:0]  pulseEnd,
  input  logic [LINE_W-1:0] firstLine,
  input  logic [LINE_W-1:0] lastLine,
  input  logic              pin1In,
  input  logic              pin2In,
  output logic              pin1Out,
  output logic              pin1Oe,
  output logic              pin2Out,
  output logic              pin2Oe,
  output logic              hSyncStrobe,
  output logic              extBlank
);
  localparam int NPINS = 2;
  refCtl_t ctl;
  logic [NPINS-1:0] pinOutV, pinOeV;

  sync_ref_ctrl uCtrl (
    .pin1Drive(pin1Drive), .pin2Drive(pin2Drive), .pin2BlankSel(pin2BlankSel),
    .syncFromPin2(syncFromPin2), .embedSync(embedSync), .ctl(ctl)
  );

  sync_ref_dp #(.PIX_W(PIX_W), .LINE_W(LINE_W), .NPINS(NPINS)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .actLow({pin2ActLow, pin1ActLow}), .pinIn({pin2In, pin1In}),
    .embSyncStrobe(embSyncStrobe),
    .pixCount(pixCount), .lineCount(lineCount),
    .pulseStart(pulseStart), .pulseEnd(pulseEnd),
    .firstLine(firstLine), .lastLine(lastLine),
    .pinOut(pinOutV), .pinOe(pinOeV),
    .hSyncStrobe(hSyncStrobe), .extBlank(extBlank)
  );

  assign pin1Out = pinOutV[0];
  assign pin2Out = pinOutV[1];
  assign pin1Oe  = pinOeV[0];
  assign pin2Oe  = pinOeV[1];

  // R2: an input pin never drives its pad
  p_input_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!pin1Drive |-> !pin1Out) and (!pin2Drive |-> !pin2Out));
endmodule

// File: tb/tb_sync_ref_top.sv
module tb_sync_ref_top;
  localparam int PIX_W  = 11;
  localparam int LINE_W = 10;

  logic clk = 0, rstN = 0;
  logic pin1ActLow = 0, pin1Drive = 0, pin2ActLow = 0, pin2Drive = 0;
  logic pin2BlankSel = 0, syncFromPin2 = 0, embedSync = 0, embSyncStrobe = 0;
  logic [PIX_W-1:0]  pixCount = '0, pulseStart = '0, pulseEnd = '0;
  logic [LINE_W-1:0] lineCount = '0, firstLine = '0, lastLine = '0;
  logic pin1In = 0, pin2In = 0;
  logic pin1Out, pin1Oe, pin2Out, pin2Oe, hSyncStrobe, extBlank;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sync_ref_top #(.PIX_W(PIX_W), .LINE_W(LINE_W)) dut (.*);

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic setPos(input int pix, input int line);
    pixCount  = PIX_W'(pix);
    lineCount = LINE_W'(line);
    tick(1);
  endtask

  task automatic testReset();
    chk(pin1Oe, 0, "R1 pin1Oe");   chk(pin2Oe, 0, "R1 pin2Oe");
    chk(pin1Out, 0, "R1 pin1Out"); chk(pin2Out, 0, "R1 pin2Out");
    chk(hSyncStrobe, 0, "R1 strobe"); chk(extBlank, 0, "R1 extBlank");
  endtask

  task automatic testHref();
    pin1Drive = 1; pin2Drive = 1; pin2BlankSel = 0;
    pulseStart = 10; pulseEnd = 20; firstLine = 20; lastLine = 200;
    tick(1);
    chk(pin1Oe, 1, "R2 pin1Oe"); chk(pin2Oe, 1, "R2 pin2Oe");
    setPos(9, 100);  chk(pin2Out, 0, "R3 before start");
    setPos(10, 100); chk(pin2Out, 1, "R3 at start");
    setPos(19, 100); chk(pin2Out, 1, "R3 last pixel");
    setPos(20, 100); chk(pin2Out, 0, "R3 at end");
    setPos(15, 2);   chk(pin2Out, 1, "R3 blanking line");
    chk(pin1Out, 1, "R10 blanking line");
  endtask

  task automatic testCbn();
    pin2BlankSel = 1;
    setPos(15, 19);  chk(pin2Out, 0, "R4 line below first");
    chk(pin1Out, 1, "R10 pin1 ignores blanksel");
    setPos(15, 20);  chk(pin2Out, 1, "R4 first line");
    setPos(15, 200); chk(pin2Out, 1, "R4 last line");
    setPos(15, 201); chk(pin2Out, 0, "R4 line above last");
    pin2BlankSel = 0;
  endtask

  task automatic testPolarity();
    pin2ActLow = 1;
    setPos(15, 100); chk(pin2Out, 0, "R5 active-low inside");
    setPos(5, 100);  chk(pin2Out, 1, "R5 active-low outside");
    pin2ActLow = 0;
  endtask

  task automatic testEmpty();
    pulseStart = 30; pulseEnd = 30;
    setPos(30, 100); chk(pin1Out, 0, "R8 equal pin1"); chk(pin2Out, 0, "R8 equal pin2");
    pulseStart = 40;
    setPos(35, 100); chk(pin1Out, 0, "R8 inverted pin1"); chk(pin2Out, 0, "R8 inverted pin2");
    pin1Drive = 0; pin2Drive = 0;
    tick(1);
    chk(pin1Oe, 0, "R2 pin1 back to input"); chk(pin1Out, 0, "R2 pin1 input low");
  endtask

  task automatic expectStrobe(input string tag);
    tick(2); chk(hSyncStrobe, 0, {tag, " early"});
    tick(1); chk(hSyncStrobe, 1, {tag, " due"});
    tick(1); chk(hSyncStrobe, 0, {tag, " width"});
  endtask

  task automatic expectNone(input string tag);
    for (int k = 0; k < 5; k++) begin
      chk(hSyncStrobe, 0, tag);
      tick(1);
    end
  endtask

  task automatic testEdges();
    syncFromPin2 = 0; embedSync = 0;
    pin1In = 1; expectStrobe("R6 pin1 rise");
    pin1In = 0; expectNone("R6 pin1 fall ignored");
    pin2In = 1; expectNone("R7 pin2 not selected");
    pin2In = 0; tick(4);
    pin1ActLow = 1; pin1In = 1; tick(4);
    pin1In = 0; expectStrobe("R5 pin1 falling edge");
    pin1ActLow = 0;
    pin1Drive = 1; tick(1);
    pin1In = 1; expectNone("R6 output pin ignored");
    pin1Drive = 0; pin1In = 0; tick(4);
  endtask

  task automatic testSource();
    syncFromPin2 = 1; tick(1);
    pin2In = 1; expectStrobe("R7 pin2 selected");
    embedSync = 1; tick(1);
    pin2In = 0; expectNone("R7 embedded ignores pins");
    embSyncStrobe = 1; tick(1);
    embSyncStrobe = 0; chk(hSyncStrobe, 1, "R7 embedded strobe");
    tick(1); chk(hSyncStrobe, 0, "R7 embedded width");
    embedSync = 0; tick(2);
  endtask

  task automatic testBlank();
    syncFromPin2 = 1; pin2BlankSel = 1; pin2In = 0; tick(4);
    chk(extBlank, 0, "R9 low level");
    pin2In = 1;
    tick(2); chk(extBlank, 0, "R9 early");
    tick(1); chk(extBlank, 1, "R9 due");
    pin2BlankSel = 0; tick(1); chk(extBlank, 0, "R9 sync-only mode");
    pin2BlankSel = 1; syncFromPin2 = 0; tick(1); chk(extBlank, 0, "R9 pin1 source");
    syncFromPin2 = 1; pin2ActLow = 1; tick(1); chk(extBlank, 0, "R9 active-low high level");
    pin2In = 0; tick(3); chk(extBlank, 1, "R9 active-low low level");
    embedSync = 1; tick(1); chk(extBlank, 0, "R9 embedded off");
    embedSync = 0; pin2Drive = 1; tick(1); chk(extBlank, 0, "R9 output off");
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected done");
    finish();
  end

  initial begin
    tick(3);
    testReset();
    rstN = 1;
    tick(1);
    testReset();
    testHref();
    testCbn();
    testPolarity();
    testEmpty();
    testEdges();
    testSource();
    testBlank();
    finish();
  end
endmodule